// File: doc/BRIEF.md
# Microsequenced Fetch-Execute Processor Core

This block is a compact 16-bit processor core that runs every instruction as a fixed chain of register transfers, one transfer per clock. All memory traffic passes through two staging registers: an address staging register that drives the memory address, and a data staging register that captures read data and supplies write data. Besides the program counter, instruction register and stack pointer, the core holds sixteen 16-bit general registers. It talks to a single-port synchronous word memory through a read strobe and a write strobe.

Every instruction is one word long. A common four-cycle fetch reads the word at the program counter and then steps the counter. An opcode-specific execute chain follows. Subroutine linkage uses a stack in main memory that grows toward lower addresses. A call pushes the return address, and a return pops it, so nested subroutines unwind in last-in-first-out order. For inspection, the program counter, the stack pointer and one selectable general register are visible at the ports.

Top module: `mseq_core`

## Requirements
- R1: While rst_ni is low, PC reads 0, SP reads 16'hFFFF, both strobes are low and halted_o is low. One clock after reset is released, the core issues a read strobe at address 0.
- R2: The fetch takes four cycles: address load, read strobe, capture of the data, and an instruction-register load with PC incremented by one. After the fetch, PC holds the address of the word that follows the instruction.
- R3: The instruction word has four fields. The opcode is bits 15:12, the destination register index is bits 11:8, the source register index is bits 3:0, and the 8-bit literal is bits 7:0. The opcodes are: 0 halt, 1 load, 2 literal, 3 jump, 4 jump-if-zero, 5 jump-if-overflow, 6 call, 7 return, 8 add. Every other opcode is a one-cycle no-operation.
- R4: Load writes the memory word at the address held in the source register into the destination register. It sets the zero flag from that value and clears the overflow flag. Its execute chain is four cycles.
- R5: Literal writes the zero-extended 8-bit literal into the destination register. It updates the flags the same way a load does.
- R6: Jump loads PC from the source register, and the next fetch reads from that address.
- R7: Jump-if-zero loads PC from the source register only when the zero flag is set. Jump-if-overflow does the same only when the overflow flag is set. Otherwise PC keeps the sequential address.
- R8: Call first decrements SP. It then writes the return address (the already-incremented PC) to memory at the new SP, and finally loads PC from the source register.
- R9: Return reads the word at SP into PC and then increments SP.
- R10: Add writes destination plus source (modulo 2^16) into the destination register. It sets the zero flag when the sum is zero, and sets the overflow flag when the two operands share a sign bit that differs from the sign bit of the sum.
- R11: The read and write strobes are never high in the same cycle. Read data is taken one clock after the read strobe.
- R12: Halt raises halted_o. From then until reset, no strobe is issued and neither PC nor SP changes.
- R13: Each instruction costs four fetch cycles plus its execute chain. The chain is four cycles for load, call and return, and one cycle for every other opcode, including halt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_addr_o | output | 16 | Memory word address (address staging register) |
| mem_wdata_o | output | 16 | Memory write data (data staging register) |
| mem_rdata_i | input | 16 | Memory read data, valid one clock after the read strobe |
| mem_rd_o | output | 1 | Read strobe |
| mem_wr_o | output | 1 | Write strobe |
| halted_o | output | 1 | High once a halt instruction has executed |
| pc_o | output | 16 | Program counter |
| sp_o | output | 16 | Stack pointer |
| obs_sel_i | input | 4 | General register index to observe |
| obs_data_o | output | 16 | Contents of the selected general register |

## Verification
The case hardest to reach is return linkage three levels deep. Reaching it needs subroutine addresses built up in registers from literals, a conditional jump taken inside the innermost routine, and stack words that each land at a distinct lower address before they are unwound. A directed program sets this up. The stack words and all final state are compared against a bench instruction model. The overflow-taken branch also needs a sign-crossing add; a directed doubling chain provides it. Seeded random programs then mix loads, adds, literals and forward conditional skips, whose flags come from random data.

// File: rtl/mseq_pkg.sv
package mseq_pkg;

  localparam logic [3:0] OP_HLT  = 4'h0;
  localparam logic [3:0] OP_LD   = 4'h1;
  localparam logic [3:0] OP_LIT  = 4'h2;
  localparam logic [3:0] OP_JMP  = 4'h3;
  localparam logic [3:0] OP_JZ   = 4'h4;
  localparam logic [3:0] OP_JV   = 4'h5;
  localparam logic [3:0] OP_CALL = 4'h6;
  localparam logic [3:0] OP_RET  = 4'h7;
  localparam logic [3:0] OP_ADD  = 4'h8;

  typedef enum logic [3:0] {
    ST_F0, ST_F1, ST_F2, ST_F3, ST_X0, ST_X1, ST_X2, ST_X3, ST_HALT
  } state_e;

  typedef enum logic [1:0] {AR_HOLD, AR_PC, AR_RS, AR_SP} ar_sel_e;
  typedef enum logic [1:0] {DR_HOLD, DR_MEM, DR_PC} dr_sel_e;
  typedef enum logic [1:0] {PC_HOLD, PC_INC, PC_RS, PC_DR} pc_sel_e;
  typedef enum logic [1:0] {SP_HOLD, SP_DEC, SP_INC} sp_sel_e;
  typedef enum logic [1:0] {WB_NONE, WB_DR, WB_LIT, WB_ALU} wb_sel_e;

  typedef struct packed {
    ar_sel_e ar_sel;
    dr_sel_e dr_sel;
    pc_sel_e pc_sel;
    sp_sel_e sp_sel;
    wb_sel_e wb_sel;
    logic    ir_load;
    logic    mem_rd;
    logic    mem_wr;
    logic    halted;
  } ctl_t;

endpackage

// File: rtl/mseq_regfile.sv
module mseq_regfile #(
  parameter int unsigned WIDTH = 16,
  parameter int unsigned COUNT = 16,
  localparam int unsigned IDX_W = $clog2(COUNT)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [IDX_W-1:0] ra_i,
  output logic [WIDTH-1:0] ra_data_o,
  input  logic [IDX_W-1:0] rb_i,
  output logic [WIDTH-1:0] rb_data_o,
  input  logic [IDX_W-1:0] rc_i,
  output logic [WIDTH-1:0] rc_data_o
);

  logic [COUNT-1:0][WIDTH-1:0] regs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      regs_q <= '0;
    end else if (we_i) begin
      for (int i = 0; i < int'(COUNT); i++) begin
        if (waddr_i == IDX_W'(i)) regs_q[i] <= wdata_i;
      end
    end
  end

  assign ra_data_o = regs_q[ra_i];
  assign rb_data_o = regs_q[rb_i];
  assign rc_data_o = regs_q[rc_i];

  // only the addressed register may change on a write
  p_single_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && rc_i != waddr_i) |=> $stable(rc_data_o) || $past(rc_i) != rc_i);

endmodule

// File: rtl/mseq_alu.sv
module mseq_alu #(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             pass_i,
  input  logic [WIDTH-1:0] pass_val_i,
  output logic [WIDTH-1:0] res_o,
  output logic             zero_o,
  output logic             ovf_o
);

  logic [WIDTH-1:0] sum;
  logic             sum_ovf;

  always_comb begin
    sum     = a_i + b_i;
    sum_ovf = (a_i[WIDTH-1] == b_i[WIDTH-1]) && (sum[WIDTH-1] != a_i[WIDTH-1]);
    res_o   = pass_i ? pass_val_i : sum;
    zero_o  = (res_o == '0);
    ovf_o   = pass_i ? 1'b0 : sum_ovf;
  end

endmodule

// File: rtl/mseq_ctrl.sv
module mseq_ctrl
  import mseq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [3:0] op_i,
  input  logic       zf_i,
  input  logic       vf_i,
  output state_e     state_o,
  output ctl_t       ctl_o
);

  state_e state_q, state_d;
  logic   long_op;

  assign long_op = (op_i == OP_LD) || (op_i == OP_CALL) || (op_i == OP_RET);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_F0;
    else         state_q <= state_d;
  end

  always_comb begin
    unique case (state_q)
      ST_F0:   state_d = ST_F1;
      ST_F1:   state_d = ST_F2;
      ST_F2:   state_d = ST_F3;
      ST_F3:   state_d = ST_X0;
      ST_X0:   state_d = (op_i == OP_HLT) ? ST_HALT : (long_op ? ST_X1 : ST_F0);
      ST_X1:   state_d = ST_X2;
      ST_X2:   state_d = ST_X3;
      ST_X3:   state_d = ST_F0;
      ST_HALT: state_d = ST_HALT;
      default: state_d = ST_F0;
    endcase
  end

  always_comb begin
    ctl_o = '0;
    case (state_q)
      ST_F0: ctl_o.ar_sel = AR_PC;
      ST_F1: ctl_o.mem_rd = 1'b1;
      ST_F2: ctl_o.dr_sel = DR_MEM;
      ST_F3: begin
        ctl_o.ir_load = 1'b1;
        ctl_o.pc_sel  = PC_INC;
      end
      ST_X0: begin
        case (op_i)
          OP_LD:   ctl_o.ar_sel = AR_RS;
          OP_LIT:  ctl_o.wb_sel = WB_LIT;
          OP_JMP:  ctl_o.pc_sel = PC_RS;
          OP_JZ:   ctl_o.pc_sel = zf_i ? PC_RS : PC_HOLD;
          OP_JV:   ctl_o.pc_sel = vf_i ? PC_RS : PC_HOLD;
          OP_CALL: ctl_o.sp_sel = SP_DEC;
          OP_RET:  ctl_o.ar_sel = AR_SP;
          OP_ADD:  ctl_o.wb_sel = WB_ALU;
          default: ;
        endcase
      end
      ST_X1: begin
        case (op_i)
          OP_LD, OP_RET: ctl_o.mem_rd = 1'b1;
          OP_CALL: begin
            ctl_o.ar_sel = AR_SP;
            ctl_o.dr_sel = DR_PC;
          end
          default: ;
        endcase
      end
      ST_X2: begin
        case (op_i)
          OP_LD, OP_RET: ctl_o.dr_sel = DR_MEM;
          OP_CALL:       ctl_o.mem_wr = 1'b1;
          default: ;
        endcase
      end
      ST_X3: begin
        case (op_i)
          OP_LD:   ctl_o.wb_sel = WB_DR;
          OP_CALL: ctl_o.pc_sel = PC_RS;
          OP_RET: begin
            ctl_o.pc_sel = PC_DR;
            ctl_o.sp_sel = SP_INC;
          end
          default: ;
        endcase
      end
      ST_HALT: ctl_o.halted = 1'b1;
      default: ;
    endcase
  end

  assign state_o = state_q;

  p_long_chain_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_X0 && long_op) |=> ##2 (state_q == ST_X3));

endmodule

// File: rtl/mseq_core.sv
module mseq_core
  import mseq_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned REG_CNT = 16,
  parameter logic [DATA_W-1:0] SP_RESET = '1,
  localparam int unsigned IDX_W = $clog2(REG_CNT),
  localparam int unsigned LIT_W = 8,
  localparam int unsigned OP_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [DATA_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic              halted_o,
  output logic [DATA_W-1:0] pc_o,
  output logic [DATA_W-1:0] sp_o,
  input  logic [IDX_W-1:0]  obs_sel_i,
  output logic [DATA_W-1:0] obs_data_o
);

  logic [DATA_W-1:0] pc_q, sp_q, ar_q, dr_q, ir_q;
  logic              zf_q, vf_q;
  ctl_t              ctl;
  state_e            state;

  logic [OP_W-1:0]   op;
  logic [IDX_W-1:0]  rd_idx, rs_idx;
  logic [DATA_W-1:0] lit_val, rs_val, rd_val;
  logic [DATA_W-1:0] alu_res;
  logic              alu_z, alu_v;
  logic              wb_en;

  assign op      = ir_q[DATA_W-1 -: OP_W];
  assign rd_idx  = ir_q[8 +: IDX_W];
  assign rs_idx  = ir_q[0 +: IDX_W];
  assign lit_val = {{(DATA_W-LIT_W){1'b0}}, ir_q[LIT_W-1:0]};
  assign wb_en   = (ctl.wb_sel != WB_NONE);

  mseq_ctrl u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .op_i    (op),
    .zf_i    (zf_q),
    .vf_i    (vf_q),
    .state_o (state),
    .ctl_o   (ctl)
  );

  mseq_regfile #(.WIDTH(DATA_W), .COUNT(REG_CNT)) u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (wb_en),
    .waddr_i   (rd_idx),
    .wdata_i   (alu_res),
    .ra_i      (rs_idx),
    .ra_data_o (rs_val),
    .rb_i      (rd_idx),
    .rb_data_o (rd_val),
    .rc_i      (obs_sel_i),
    .rc_data_o (obs_data_o)
  );

  mseq_alu #(.WIDTH(DATA_W)) u_alu (
    .a_i        (rd_val),
    .b_i        (rs_val),
    .pass_i     (ctl.wb_sel != WB_ALU),
    .pass_val_i ((ctl.wb_sel == WB_DR) ? dr_q : lit_val),
    .res_o      (alu_res),
    .zero_o     (alu_z),
    .ovf_o      (alu_v)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q <= '0;
      sp_q <= SP_RESET;
      ar_q <= '0;
      dr_q <= '0;
      ir_q <= '0;
      zf_q <= 1'b0;
      vf_q <= 1'b0;
    end else begin
      case (ctl.ar_sel)
        AR_PC:   ar_q <= pc_q;
        AR_RS:   ar_q <= rs_val;
        AR_SP:   ar_q <= sp_q;
        default: ;
      endcase
      case (ctl.dr_sel)
        DR_MEM:  dr_q <= mem_rdata_i;
        DR_PC:   dr_q <= pc_q;
        default: ;
      endcase
      if (ctl.ir_load) ir_q <= dr_q;
      case (ctl.pc_sel)
        PC_INC:  pc_q <= pc_q + 1'b1;
        PC_RS:   pc_q <= rs_val;
        PC_DR:   pc_q <= dr_q;
        default: ;
      endcase
      case (ctl.sp_sel)
        SP_DEC:  sp_q <= sp_q - 1'b1;
        SP_INC:  sp_q <= sp_q + 1'b1;
        default: ;
      endcase
      if (wb_en) begin
        zf_q <= alu_z;
        vf_q <= alu_v;
      end
    end
  end

  assign mem_addr_o  = ar_q;
  assign mem_wdata_o = dr_q;
  assign mem_rd_o    = ctl.mem_rd;
  assign mem_wr_o    = ctl.mem_wr;
  assign halted_o    = ctl.halted;
  assign pc_o        = pc_q;
  assign sp_o        = sp_q;

  p_one_strobe_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o));

  p_pc_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_F3) |=> (pc_q == $past(pc_q) + 1'b1));

  p_push_at_sp_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |-> (mem_addr_o == sp_q && mem_wdata_o == pc_q));

  p_pop_bump_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_X3 && op == OP_RET) |=> (sp_q == $past(sp_q) + 1'b1));

  p_jz_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_X0 && op == OP_JZ && !zf_q) |=> $stable(pc_q));

  p_halt_quiet_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> (halted_o && !mem_rd_o && !mem_wr_o && $stable(pc_q) && $stable(sp_q)));

endmodule

// File: tb/mseq_core_tb.sv
module mseq_core_tb;

  localparam int MEM_N = 1024;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] mem_addr, mem_wdata, mem_rdata, pc, sp, obs_data;
  logic        mem_rd, mem_wr, halted;
  logic [3:0]  obs_sel = '0;

  always #5 clk = ~clk;

  mseq_core u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .mem_addr_o  (mem_addr),
    .mem_wdata_o (mem_wdata),
    .mem_rdata_i (mem_rdata),
    .mem_rd_o    (mem_rd),
    .mem_wr_o    (mem_wr),
    .halted_o    (halted),
    .pc_o        (pc),
    .sp_o        (sp),
    .obs_sel_i   (obs_sel),
    .obs_data_o  (obs_data)
  );

  logic [15:0] mem  [MEM_N];
  logic [15:0] mmem [MEM_N];

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr[9:0]];
    if (mem_wr) mem[mem_addr[9:0]] <= mem_wdata;
  end

  int checks = 0, errors = 0, strobe_bad = 0;
  bit finished = 0;

  always @(negedge clk) if (rst_ni && mem_rd && mem_wr) strobe_bad++;

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", what, act, exp);
    end
  endtask

  function automatic logic [15:0] ins(input logic [3:0] op, input logic [3:0] rd, input logic [3:0] rs);
    return {op, rd, 4'h0, rs};
  endfunction

  function automatic logic [15:0] lit(input logic [3:0] rd, input logic [7:0] v);
    return {4'h2, rd, v};
  endfunction

  // instruction-level model built from the requirements
  logic [15:0] m_regs [16];
  logic [15:0] m_pc, m_sp;
  int          m_cyc;

  task automatic model_run();
    logic [15:0] w, a, b, s;
    logic [3:0]  rd, rs;
    logic        z, v;
    bit          done;
    m_pc = '0; m_sp = 16'hFFFF; m_cyc = 0; z = 0; v = 0; done = 0;
    for (int r = 0; r < 16; r++) m_regs[r] = '0;
    for (int step = 0; step < 4000 && !done; step++) begin
      w = mmem[m_pc[9:0]];
      m_pc = m_pc + 1;
      m_cyc += 4;
      rd = w[11:8]; rs = w[3:0];
      case (w[15:12])
        4'h0: begin m_cyc += 1; done = 1; end
        4'h1: begin s = mmem[m_regs[rs][9:0]]; m_regs[rd] = s; z = (s == 0); v = 0; m_cyc += 4; end
        4'h2: begin s = {8'h00, w[7:0]}; m_regs[rd] = s; z = (s == 0); v = 0; m_cyc += 1; end
        4'h3: begin m_pc = m_regs[rs]; m_cyc += 1; end
        4'h4: begin if (z) m_pc = m_regs[rs]; m_cyc += 1; end
        4'h5: begin if (v) m_pc = m_regs[rs]; m_cyc += 1; end
        4'h6: begin m_sp = m_sp - 1; mmem[m_sp[9:0]] = m_pc; m_pc = m_regs[rs]; m_cyc += 4; end
        4'h7: begin m_pc = mmem[m_sp[9:0]]; m_sp = m_sp + 1; m_cyc += 4; end
        4'h8: begin
          a = m_regs[rd]; b = m_regs[rs]; s = a + b;
          v = (a[15] == b[15]) && (s[15] != a[15]); z = (s == 0);
          m_regs[rd] = s; m_cyc += 1;
        end
        default: m_cyc += 1;
      endcase
    end
  endtask

  task automatic fill_random();
    for (int i = 0; i < MEM_N; i++) mem[i] = 16'($urandom);
  endtask

  task automatic run_case(input string tag, input bit first);
    int cyc, bad;
    logic [15:0] pc_h;
    bit quiet;
    for (int i = 0; i < MEM_N; i++) mmem[i] = mem[i];
    model_run();
    @(negedge clk);
    if (first) begin
      chk(pc == 16'h0, "R1 reset PC", pc, 0);
      chk(sp == 16'hFFFF, "R1 reset SP", sp, 16'hFFFF);
      chk(!mem_rd && !mem_wr && !halted, "R1 reset strobes", {mem_rd, mem_wr, halted}, 0);
    end
    rst_ni = 1'b1;
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
      if (first && cyc == 1)
        chk(mem_rd && mem_addr == 16'h0, "R1 R2 first fetch read at 0", {mem_rd, mem_addr}, 32'h10000);
      if (halted || cyc > 50000) break;
    end
    chk(halted, {tag, " R12 halt reached"}, halted, 1);
    chk(cyc == m_cyc, {tag, " R13 cycle count"}, cyc, m_cyc);
    chk(pc == m_pc, {tag, " R2 R6 R7 R8 R9 final PC"}, pc, m_pc);
    chk(sp == m_sp, {tag, " R8 R9 final SP"}, sp, m_sp);
    for (int r = 0; r < 16; r++) begin
      obs_sel = 4'(r);
      #1;
      chk(obs_data == m_regs[r], $sformatf("%s R3 R4 R5 R10 reg %0d", tag, r), obs_data, m_regs[r]);
    end
    bad = 0;
    for (int i = 0; i < MEM_N; i++) if (mem[i] !== mmem[i]) bad++;
    chk(bad == 0, {tag, " R8 memory and stack image mismatches"}, bad, 0);
    pc_h = pc;
    quiet = 1;
    repeat (6) begin
      @(negedge clk);
      if (mem_rd || mem_wr || pc != pc_h || !halted) quiet = 0;
    end
    chk(quiet, {tag, " R12 quiet after halt"}, pc, pc_h);
    rst_ni = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h5EED));

    // nested calls three deep, conditional skip in the innermost routine
    fill_random();
    mem[0] = lit(4'd1, 8'h20);
    mem[1] = lit(4'd2, 8'h30);
    mem[2] = lit(4'd3, 8'h40);
    mem[3] = lit(4'd5, 8'h80);
    mem[4] = ins(4'h6, 4'd0, 4'd1);
    mem[5] = ins(4'h1, 4'd6, 4'd5);
    mem[6] = ins(4'h0, 4'd0, 4'd0);
    mem[16'h80] = 16'h1234;
    mem[16'h20] = lit(4'd7, 8'h11);
    mem[16'h21] = ins(4'h6, 4'd0, 4'd2);
    mem[16'h22] = ins(4'h7, 4'd0, 4'd0);
    mem[16'h30] = lit(4'd8, 8'h22);
    mem[16'h31] = ins(4'h6, 4'd0, 4'd3);
    mem[16'h32] = ins(4'h7, 4'd0, 4'd0);
    mem[16'h40] = lit(4'd9, 8'h33);
    mem[16'h41] = lit(4'd11, 8'h45);
    mem[16'h42] = lit(4'd10, 8'h00);
    mem[16'h43] = ins(4'h4, 4'd0, 4'd11);
    mem[16'h44] = lit(4'd9, 8'hEE);
    mem[16'h45] = ins(4'h7, 4'd0, 4'd0);
    run_case("nested R8 R9", 1'b1);
    chk(mmem[10'h3FC] == 16'h0032 && mmem[10'h3FE] == 16'h0005, "R8 pushed return words",
        {mmem[10'h3FC], mmem[10'h3FE]}, 32'h00320005);
    chk(m_regs[9] == 16'h0033 && m_regs[6] == 16'h1234, "R4 R7 directed expectation",
        {m_regs[9], m_regs[6]}, 32'h00331234);

    // overflow and zero branches, unconditional jump
    fill_random();
    mem[0] = lit(4'd1, 8'h40);
    for (int i = 1; i <= 8; i++) mem[i] = ins(4'h8, 4'd1, 4'd1);
    mem[9]  = lit(4'd2, 8'h0E);
    mem[10] = ins(4'h5, 4'd0, 4'd2);
    mem[11] = ins(4'h8, 4'd1, 4'd1);
    mem[12] = ins(4'h5, 4'd0, 4'd2);
    mem[13] = lit(4'd3, 8'h99);
    mem[14] = lit(4'd5, 8'h12);
    mem[15] = lit(4'd4, 8'h00);
    mem[16] = ins(4'h4, 4'd0, 4'd5);
    mem[17] = lit(4'd3, 8'h77);
    mem[18] = lit(4'd6, 8'h15);
    mem[19] = ins(4'h3, 4'd0, 4'd6);
    mem[20] = lit(4'd3, 8'h55);
    mem[21] = ins(4'h0, 4'd0, 4'd0);
    run_case("branch R6 R7 R10", 1'b0);
    chk(m_regs[1] == 16'h8000 && m_regs[3] == 16'h0000, "R7 R10 overflow skip",
        {m_regs[1], m_regs[3]}, 32'h80000000);

    // seeded random programs with forward conditional skips
    for (int p = 0; p < 6; p++) begin
      int i;
      fill_random();
      i = 0;
      while (i < 26) begin
        int r;
        r = int'($urandom % 10);
        if (r >= 8 && i < 22) begin
          mem[i]     = lit(4'd15, 8'(i + 4));
          mem[i + 1] = ins(($urandom % 2) ? 4'h8 : 4'h1, 4'($urandom % 15), 4'($urandom % 15));
          mem[i + 2] = ins(($urandom % 2) ? 4'h4 : 4'h5, 4'd0, 4'd15);
          mem[i + 3] = lit(4'($urandom % 15), 8'($urandom));
          i += 4;
        end else begin
          case (r)
            0, 1, 2: mem[i] = lit(4'($urandom % 15), 8'($urandom));
            3, 4:    mem[i] = ins(4'h8, 4'($urandom % 15), 4'($urandom % 15));
            5, 6:    mem[i] = ins(4'h1, 4'($urandom % 15), 4'($urandom % 15));
            default: mem[i] = ins(4'hF, 4'd0, 4'd0);
          endcase
          i++;
        end
      end
      mem[i] = ins(4'h0, 4'd0, 4'd0);
      run_case($sformatf("random %0d R4 R5 R7 R10", p), 1'b0);
    end

    chk(strobe_bad == 0, "R11 strobes overlap count", strobe_bad, 0);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule